// File: doc/BRIEF.md
# Complementary Output Enable Stage

This block sits behind the compare logic of a multi-channel timer. For each channel it turns the compare reference bit into a main output pin, and on the lower channels also a complementary pin. Each pin has its own output-enable. Per-output enable bits, per-output polarity bits and per-output idle levels shape the pins. Three global bits choose the operating state: a primary output-enable, a run-mode off-state select and an idle-mode off-state select. The primary output-enable is a plain input. Dead-time insertion, break detection and register access belong to other blocks.

Each channel's pin values and output-enables are computed in one combinational stage and captured in registers. Every pin therefore reflects the inputs sampled at the previous rising clock edge. The number of channels and the number of channels with a complementary output are parameters. The defaults are four channels, of which the first three are complementary.

Top module: `cmp_pair_out`

## Requirements
- R1: A synchronous active-low reset drives every pin value and every output-enable to 0 at the next rising edge.
- R2: When the primary enable is 0 and the idle off-state select is 0, every pin is 0 with its driver off, whatever the channel enables are.
- R3: When the primary enable is 0 and the idle off-state select is 1, a channel with at least one of its enables set drives its main pin to its idle level and its complementary pin to its idle level, both drivers on. A channel with neither enable set is 0 with drivers off.
- R4: When the primary enable is 1 and both enables of a channel are set, the main pin is the reference XOR the main polarity bit, and the complementary pin is the inverted reference XOR the complementary polarity bit. Both drivers are on.
- R5: When the primary enable is 1 and exactly one enable of a channel is set, that output follows the reference as in R4 with its driver on. The other output sits at its own polarity bit (its inactive level), with its driver on only if the run off-state select is 1.
- R6: When the primary enable is 1 and neither enable of a channel is set, both pins sit at their polarity bits with drivers on if the run off-state select is 1. Otherwise both are 0 with drivers off.
- R7: The active level of a main pin is the inverse of its polarity bit, and likewise for a complementary pin. A pair never has both pins driven at their active levels. An idle-level setting that would do so is resolved by driving the complementary pin to its polarity bit.
- R8: A channel at or above the complementary count (bit index 3 by default) always has its complementary pin at 0 with the driver off. Its complementary enable, polarity and idle bits are ignored, and its main pin behaves as if its complementary enable were 0.
- R9: Pins and drivers change exactly one clock after the inputs that select them are sampled, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prim_en | input | 1 | Primary output-enable |
| run_off | input | 1 | Run-mode off-state select |
| idle_off | input | 1 | Idle-mode off-state select |
| ref_i | input | NUM_CH | Compare reference per channel (bit i = channel i) |
| en_main | input | NUM_CH | Main output enable per channel |
| en_comp | input | NUM_CH | Complementary output enable per channel |
| pol_main | input | NUM_CH | Main polarity bit (1 = inverted) |
| pol_comp | input | NUM_CH | Complementary polarity bit (1 = inverted) |
| idle_main | input | NUM_CH | Main idle level |
| idle_comp | input | NUM_CH | Complementary idle level |
| out_main | output | NUM_CH | Main pin value |
| oe_main | output | NUM_CH | Main pin driver enable |
| out_comp | output | NUM_CH | Complementary pin value |
| oe_comp | output | NUM_CH | Complementary pin driver enable |

## Verification
The state in this block is just the output register, so a wrong next-state selection shows up at the pins one clock after the offending input combination. The bench model compares every pin and driver-enable on every cycle. Directed phases force each global state and each pattern of channel enables. These phases include the idle-level conflict and the channel with no complementary output, so a swapped case arm or a missed guard shows within the first few cycles of its phase. A long random phase then mixes all combinations and changes them cycle by cycle, which catches latency errors and cross-channel wiring mistakes.

// File: rtl/cmp_pair_pkg.sv
// Shared types for the complementary output stage.
package cmp_pair_pkg;

    // Global operating state, decoded from the primary enable and idle select.
    typedef enum logic [1:0] {
        CM_OFF  = 2'd0,
        CM_IDLE = 2'd1,
        CM_RUN  = 2'd2
    } cop_mode_e;

    // One pin: level and driver enable.
    typedef struct packed {
        logic lvl;
        logic oe;
    } pin_t;

endpackage

// File: rtl/cmp_pair_mode.sv
// Decodes the global operating state.
// Assumes the global bits are synchronous to clk; purely combinational.
module cmp_pair_mode
    import cmp_pair_pkg::*;
(
    input  logic      prim_en,
    input  logic      idle_off,
    output cop_mode_e mode
);

    // Priority: primary enable selects run, else the idle select chooses.
    always_comb begin
        if (prim_en)       mode = CM_RUN;
        else if (idle_off) mode = CM_IDLE;
        else               mode = CM_OFF;
    end

endmodule

// File: rtl/cmp_pair_chan.sv
// Next-state logic for one channel's main and complementary pins.
// HAS_COMP = 0 removes the complementary pin (forced low, driver off).
// Assumes the mode is already decoded; purely combinational.
module cmp_pair_chan
    import cmp_pair_pkg::*;
#(
    parameter bit HAS_COMP = 1'b1
) (
    input  cop_mode_e mode,
    input  logic      run_off,
    input  logic      ref_i,
    input  logic      en_m,
    input  logic      en_c,
    input  logic      pol_m,
    input  logic      pol_c,
    input  logic      idle_m,
    input  logic      idle_c,
    output pin_t      nxt_m,
    output pin_t      nxt_c
);

    logic act_m;
    logic act_c;
    logic eff_c;

    // Select pin levels and drivers from mode and the channel enables.
    always_comb begin
        act_m = ref_i ^ pol_m;
        act_c = ~ref_i ^ pol_c;
        eff_c = en_c & HAS_COMP;
        nxt_m = '0;
        nxt_c = '0;
        unique case (mode)
            CM_IDLE: begin
                if (en_m | eff_c) begin
                    nxt_m = '{lvl: idle_m, oe: 1'b1};
                    nxt_c = '{lvl: idle_c, oe: 1'b1};
                    // both idle levels active: push complementary inactive
                    if ((idle_m != pol_m) && (idle_c != pol_c))
                        nxt_c.lvl = pol_c;
                end
            end
            CM_RUN: begin
                unique case ({en_m, eff_c})
                    2'b11: begin
                        nxt_m = '{lvl: act_m, oe: 1'b1};
                        nxt_c = '{lvl: act_c, oe: 1'b1};
                    end
                    2'b10: begin
                        nxt_m = '{lvl: act_m, oe: 1'b1};
                        nxt_c = '{lvl: pol_c, oe: run_off};
                    end
                    2'b01: begin
                        nxt_m = '{lvl: pol_m, oe: run_off};
                        nxt_c = '{lvl: act_c, oe: 1'b1};
                    end
                    default: begin
                        if (run_off) begin
                            nxt_m = '{lvl: pol_m, oe: 1'b1};
                            nxt_c = '{lvl: pol_c, oe: 1'b1};
                        end
                    end
                endcase
            end
            default: ;
        endcase
        if (!HAS_COMP) nxt_c = '0;
    end

endmodule

// File: rtl/cmp_pair_reg.sv
// Output register bank with synchronous active-low reset to all zeros.
module cmp_pair_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture next pin state; reset clears levels and drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cmp_pair_out.sv
// Complementary output enable stage: per channel, a main pin and, on the
// first NUM_COMP channels, a complementary pin, each with a driver enable.
// Assumes all inputs are synchronous to clk; outputs are registered.
module cmp_pair_out
    import cmp_pair_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_COMP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prim_en,
    input  logic              run_off,
    input  logic              idle_off,
    input  logic [NUM_CH-1:0] ref_i,
    input  logic [NUM_CH-1:0] en_main,
    input  logic [NUM_CH-1:0] en_comp,
    input  logic [NUM_CH-1:0] pol_main,
    input  logic [NUM_CH-1:0] pol_comp,
    input  logic [NUM_CH-1:0] idle_main,
    input  logic [NUM_CH-1:0] idle_comp,
    output logic [NUM_CH-1:0] out_main,
    output logic [NUM_CH-1:0] oe_main,
    output logic [NUM_CH-1:0] out_comp,
    output logic [NUM_CH-1:0] oe_comp
);

    localparam int PIN_W = $bits(pin_t);
    localparam int REG_W = 2 * PIN_W * NUM_CH;

    cop_mode_e        mode;
    pin_t [NUM_CH-1:0] nxt_m;
    pin_t [NUM_CH-1:0] nxt_c;
    pin_t [NUM_CH-1:0] cur_m;
    pin_t [NUM_CH-1:0] cur_c;

    cmp_pair_mode u_mode (
        .prim_en  (prim_en),
        .idle_off (idle_off),
        .mode     (mode)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmp_pair_chan #(
            .HAS_COMP (c < NUM_COMP)
        ) u_chan (
            .mode    (mode),
            .run_off (run_off),
            .ref_i   (ref_i[c]),
            .en_m    (en_main[c]),
            .en_c    (en_comp[c]),
            .pol_m   (pol_main[c]),
            .pol_c   (pol_comp[c]),
            .idle_m  (idle_main[c]),
            .idle_c  (idle_comp[c]),
            .nxt_m   (nxt_m[c]),
            .nxt_c   (nxt_c[c])
        );

        // Unpack registered pin state to the port vectors.
        always_comb begin
            out_main[c] = cur_m[c].lvl;
            oe_main[c]  = cur_m[c].oe;
            out_comp[c] = cur_c[c].lvl;
            oe_comp[c]  = cur_c[c].oe;
        end
    end

    cmp_pair_reg #(
        .W (REG_W)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nxt_m, nxt_c}),
        .q     ({cur_m, cur_c})
    );

endmodule

// File: rtl/cmp_pair_out_chk.sv
// Property checker for cmp_pair_out, attached through bind below.
module cmp_pair_out_chk #(
    parameter int NUM_CH   = 4,
    parameter int NUM_COMP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prim_en,
    input logic              run_off,
    input logic              idle_off,
    input logic [NUM_CH-1:0] ref_i,
    input logic [NUM_CH-1:0] en_main,
    input logic [NUM_CH-1:0] en_comp,
    input logic [NUM_CH-1:0] pol_main,
    input logic [NUM_CH-1:0] pol_comp,
    input logic [NUM_CH-1:0] idle_main,
    input logic [NUM_CH-1:0] idle_comp,
    input logic [NUM_CH-1:0] out_main,
    input logic [NUM_CH-1:0] oe_main,
    input logic [NUM_CH-1:0] out_comp,
    input logic [NUM_CH-1:0] oe_comp
);

    logic seen = 1'b0;

    // Remember whether the previous edge was out of reset.
    always_ff @(posedge clk) seen <= rst_n;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_main == '0 && oe_main == '0 && out_comp == '0 && oe_comp == '0));

    // R2
    off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!prim_en && !idle_off) |->
            (out_main == '0 && oe_main == '0 && out_comp == '0 && oe_comp == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3
        idle_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(!prim_en && idle_off && en_main[c]) |->
                (oe_main[c] && out_main[c] == $past(idle_main[c])));

        // R6
        run_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(prim_en && !en_main[c] && (c >= NUM_COMP || !en_comp[c]) && !run_off) |->
                (!oe_main[c] && !out_main[c]));

        if (c < NUM_COMP) begin : g_pair
            // R3
            idle_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                seen && $past(!prim_en && idle_off && en_comp[c] && idle_main[c] == pol_main[c]) |->
                    (oe_comp[c] && out_comp[c] == $past(idle_comp[c])));

            // R4
            run_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
                seen && $past(prim_en && en_main[c] && en_comp[c]) |->
                    (oe_main[c] && oe_comp[c] &&
                     out_main[c] == $past(ref_i[c] ^ pol_main[c]) &&
                     out_comp[c] == $past(~ref_i[c] ^ pol_comp[c])));

            // R7
            never_both_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
                seen |-> !(oe_main[c] && oe_comp[c] &&
                           out_main[c] != $past(pol_main[c]) &&
                           out_comp[c] != $past(pol_comp[c])));
        end else begin : g_single
            // R8
            no_comp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !out_comp[c] && !oe_comp[c]);
        end
    end

endmodule

bind cmp_pair_out cmp_pair_out_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_COMP (NUM_COMP)
) chk_i (.*);

// File: tb/cmp_pair_out_tb_top.sv
// Self-checking bench: behavioural per-pin model compared on every clock.
module cmp_pair_out_tb_top;

    localparam int NCH = 4;
    localparam int NCO = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           prim_en = 1'b0, run_off = 1'b0, idle_off = 1'b0;
    logic [NCH-1:0] ref_i = '0, en_main = '0, en_comp = '0;
    logic [NCH-1:0] pol_main = '0, pol_comp = '0, idle_main = '0, idle_comp = '0;
    logic [NCH-1:0] out_main, oe_main, out_comp, oe_comp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected values for the next compare
    bit [NCH-1:0] x_om, x_em, x_oc, x_ec;

    always #5 clk = ~clk;

    cmp_pair_out #(.NUM_CH(NCH), .NUM_COMP(NCO)) dut_i (
        .clk, .rst_n, .prim_en, .run_off, .idle_off, .ref_i,
        .en_main, .en_comp, .pol_main, .pol_comp, .idle_main, .idle_comp,
        .out_main, .oe_main, .out_comp, .oe_comp
    );

    // Spec model: each output computed on its own from the requirements.
    task automatic model();
        for (int c = 0; c < NCH; c++) begin
            bit has = (c < NCO);
            bit ec  = has && en_comp[c];
            bit any = en_main[c] || ec;
            bit m = 0, me = 0, n = 0, ne = 0;
            if (!rst_n) begin
                // R1: cleared
            end else if (!prim_en) begin
                if (idle_off && any) begin
                    m = idle_main[c]; me = 1;
                    if (has) begin
                        n = idle_comp[c]; ne = 1;
                        if (m != pol_main[c] && n != pol_comp[c]) n = pol_comp[c];
                    end
                end
            end else begin
                if (en_main[c]) m = ref_i[c] ^ pol_main[c];
                else if (ec || run_off) m = pol_main[c];
                me = en_main[c] || run_off;
                if (has) begin
                    if (ec) n = !ref_i[c] ^ pol_comp[c];
                    else if (en_main[c] || run_off) n = pol_comp[c];
                    ne = ec || run_off;
                end
            end
            x_om[c] = m; x_em[c] = me; x_oc[c] = n; x_ec[c] = ne;
        end
    endtask

    // Apply current inputs for one clock, then compare at the next falling edge.
    task automatic step(input string tag);
        model();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            n_cmp++;
            if ({out_main[c], oe_main[c], out_comp[c], oe_comp[c]} !=
                {x_om[c], x_em[c], x_oc[c], x_ec[c]}) begin
                n_bad++;
                $display("FAIL %s ch%0d: got m/oe/n/oe=%b%b%b%b expected %b%b%b%b", tag, c,
                         out_main[c], oe_main[c], out_comp[c], oe_comp[c],
                         x_om[c], x_em[c], x_oc[c], x_ec[c]);
            end
            if (c < NCO && rst_n) begin
                n_cmp++;
                if (oe_main[c] && oe_comp[c] && out_main[c] != pol_main[c] &&
                    out_comp[c] != pol_comp[c]) begin
                    n_bad++;
                    $display("FAIL R7 ch%0d: both active, got %b%b expected not both active",
                             c, out_main[c], out_comp[c]);
                end
            end
        end
    endtask

    task automatic rnd_chan();
        ref_i = $urandom; pol_main = $urandom; pol_comp = $urandom;
        idle_main = $urandom; idle_comp = $urandom;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset with busy inputs
        prim_en = 1; run_off = 1; en_main = '1; en_comp = '1; rnd_chan();
        repeat (3) step("R1 reset");
        rst_n = 1'b1;

        // R2: off state ignores enables
        prim_en = 0; idle_off = 0;
        for (int i = 0; i < 6; i++) begin
            en_main = $urandom; en_comp = $urandom; run_off = $urandom; rnd_chan();
            step("R2 off state");
        end

        // R3: idle levels, including every enable pattern
        idle_off = 1;
        for (int i = 0; i < 16; i++) begin
            en_main = $urandom; en_comp = $urandom; rnd_chan();
            step("R3 idle levels");
        end

        // R7: idle levels that would make both pins active
        pol_main = 4'b0101; pol_comp = 4'b0011;
        idle_main = ~pol_main; idle_comp = ~pol_comp; en_main = '1; en_comp = '1;
        step("R7 idle conflict");
        pol_main = 4'b1111; pol_comp = 4'b0000; idle_main = 4'b0000; idle_comp = 4'b1111;
        step("R7 idle conflict");

        // R4: run with both enables
        prim_en = 1; en_main = '1; en_comp = '1;
        foreach (ref_i[b]) ref_i[b] = 1'b0;
        pol_main = '0; pol_comp = '0; step("R4 both on ref0");
        ref_i = '1; step("R4 both on ref1");
        ref_i = 4'b1010; pol_main = 4'b0110; pol_comp = 4'b1100; step("R4 both on mixed");
        ref_i = 4'b0101; step("R4 both on mixed");

        // R5: exactly one enable, both run selects
        for (int i = 0; i < 8; i++) begin
            en_main = (i % 2) ? '1 : '0; en_comp = ~en_main; run_off = i[1];
            rnd_chan(); step("R5 single enable");
        end

        // R6: no enables
        en_main = '0; en_comp = '0;
        for (int i = 0; i < 6; i++) begin
            run_off = i[0]; rnd_chan(); step("R6 none enabled");
        end

        // R8: channel 3 complementary bits must have no effect
        en_main = 4'b0000; en_comp = 4'b1000; run_off = 0; pol_comp = 4'b1000;
        idle_comp = 4'b1000; step("R8 no comp pin");
        en_main = 4'b1000; ref_i = 4'b1000; step("R8 no comp pin");
        prim_en = 0; idle_off = 1; en_main = 4'b0000; en_comp = 4'b1000; step("R8 no comp pin");

        // R9: one-clock latency while reference toggles each cycle
        prim_en = 1; en_main = '1; en_comp = '1;
        for (int i = 0; i < 8; i++) begin
            ref_i = ~ref_i; step("R9 latency");
        end

        // mixed random phase covering R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 3000; i++) begin
            prim_en = $urandom; run_off = $urandom; idle_off = $urandom;
            en_main = $urandom; en_comp = $urandom; rnd_chan();
            step("random R2 R3 R4 R5 R6 R7 R8");
        end

        // R1: reset in mid-run
        rst_n = 1'b0; prim_en = 1; en_main = '1; step("R1 mid-run reset");
        rst_n = 1'b1; step("R1 after release");

        finish_run();
    end

endmodule